// File: doc/BRIEF.md
# DMA Channel Run-State Sequencer

This block holds the run state of one DMA channel and decides what happens when software writes the channel control bits or when the transfer engine finishes a descriptor. It keeps the channel in one of three states (off, running, held) and keeps a sticky fault flag. From these it reports a 2-bit status code. It also issues one-cycle requests to the pointer logic: one reloads the current descriptor pointers from the start pointers, the other steps the source descriptor pointer to the next entry. It sends pause, done and source-done pulses to the interrupt logic.

Software writes the enable bit, the resume bit and the resume-from-start bit in a single control write, shown by a one-cycle `ctl_wr` strobe. The engine reports a finished descriptor with `xfer_done`, together with that descriptor's command field and interrupt flag. It reports a failed descriptor fetch with `fetch_err`. The `mem_desc` input selects memory-held descriptors (1) or register-held descriptors (0). All outputs are registered, so every reaction appears on the clock edge that samples the stimulus.

Top module: `dma_run_ctrl`

## Requirements
- R1: After reset, status reads 0 and the enable and resume bits read 0. Status encodes off as 0, running as 1 and held as 2. While the fault flag is set, status reads 3 whatever the state.
- R2: A control write with enable=1 while off clears the fault flag. It pulses `ld_start_o` for one cycle, sets `enable_o` and enters running (status 1).
- R3: A control write with enable=1 and resume=1 while held clears the fault flag and enters running. It pulses `ld_start_o` if resume-from-start=1, and pulses `adv_src_o` otherwise. The resume bit reads 0 afterwards. With resume=0 the channel stays held and no request pulses.
- R4: A control write with enable=0 and resume=1 while held enters off (status 0). No pointer request pulses.
- R5: When a descriptor finishes in register mode (`mem_desc`=0), or its command equals 2, the channel enters off and `enable_o` clears. This applies in register mode even when the command is 1.
- R6: In memory mode, a finished descriptor with command 1 enters held (status 2) and pulses `pause_evt_o`. Command 0 or 3 pulses `adv_src_o`, and the channel stays running.
- R7: Every finished descriptor while running pulses `done_evt_o`. `src_done_evt_o` pulses only when the descriptor's interrupt flag is 1.
- R8: A fetch error while running forces the channel off and sets the fault flag (status 3). The fault flag stays set until the next start or resume.
- R9: Control writes are ignored while running. State, enable and resume bits do not change, and no request pulses.
- R10: `xfer_done` and `fetch_err` are ignored while off or held. No event pulses and no change of status.
- R11: If `fetch_err` and `xfer_done` arrive in the same cycle while running, the fetch error wins and no done event is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | One-cycle strobe of a control write |
| ctl_en | input | 1 | Enable value carried by the write |
| ctl_cont | input | 1 | Resume value carried by the write |
| ctl_cont_start | input | 1 | Resume-from-start value carried by the write |
| mem_desc | input | 1 | 1 = memory-held descriptors, 0 = register-held |
| xfer_done | input | 1 | Engine finished the current descriptor |
| xfer_cmd | input | CMD_W | Command field of the finished descriptor |
| xfer_intr | input | 1 | Interrupt flag of the finished descriptor |
| fetch_err | input | 1 | Descriptor fetch failed |
| status_o | output | 2 | Run status code |
| enable_o | output | 1 | Enable bit readback |
| cont_o | output | 1 | Resume bit readback |
| ld_start_o | output | 1 | Reload current pointers from start pointers |
| adv_src_o | output | 1 | Step source descriptor pointer |
| pause_evt_o | output | 1 | Pause event to interrupt logic |
| done_evt_o | output | 1 | Transfer-done event to interrupt logic |
| src_done_evt_o | output | 1 | Source descriptor done event |

## Verification
The embedded properties check on every cycle the edge-to-edge reactions. A start from off gives a reload and running status. A fetch error gives status 3. Each completion gives a done pulse. A pause pulse always comes with held status, and the two pointer requests never fire together. Only the directed scenarios can show the longer sequences: halt, resume by stepping or by reloading, leaving a hold with enable cleared, writes ignored while running, and the fault flag surviving until the next start. The bench walks through each of these in order and reads the result at the ports.

// File: rtl/rc_pkg.sv
package rc_pkg;
  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_RUN  = 2'd1,
    ST_HOLD = 2'd2
  } run_state_e;

  localparam logic [1:0] STATUS_FAULT = 2'd3;

  typedef enum logic [1:0] {
    ACT_FINISH = 2'd0,
    ACT_HOLD   = 2'd1,
    ACT_NEXT   = 2'd2
  } done_act_e;

  // event vector bit positions
  localparam int EV_LD    = 0;
  localparam int EV_ADV   = 1;
  localparam int EV_PAUSE = 2;
  localparam int EV_DONE  = 3;
  localparam int EV_SRC   = 4;
  localparam int EV_W     = 5;
endpackage

// File: rtl/rc_done_decode.sv
module rc_done_decode
  import rc_pkg::*;
#(
  parameter int CMD_W    = 2,
  parameter int STOP_CMD = 2,
  parameter int HALT_CMD = 1
) (
  input  logic             mem_desc,
  input  logic [CMD_W-1:0] cmd,
  output done_act_e        act
);
  localparam logic [CMD_W-1:0] STOP_V = CMD_W'(STOP_CMD);
  localparam logic [CMD_W-1:0] HALT_V = CMD_W'(HALT_CMD);

  // register-held descriptors always finish; stop beats halt in memory mode
  always_comb begin
    if (!mem_desc || cmd == STOP_V)
      act = ACT_FINISH;
    else if (cmd == HALT_V)
      act = ACT_HOLD;
    else
      act = ACT_NEXT;
  end
endmodule

// File: rtl/rc_pulse_reg.sv
module rc_pulse_reg #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) q[i] <= 1'b0;
      else     q[i] <= d[i];
    end
  end
endmodule

// File: rtl/dma_run_ctrl.sv
module dma_run_ctrl
  import rc_pkg::*;
#(
  parameter int CMD_W    = 2,
  parameter int STOP_CMD = 2,
  parameter int HALT_CMD = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctl_wr,
  input  logic             ctl_en,
  input  logic             ctl_cont,
  input  logic             ctl_cont_start,
  input  logic             mem_desc,
  input  logic             xfer_done,
  input  logic [CMD_W-1:0] xfer_cmd,
  input  logic             xfer_intr,
  input  logic             fetch_err,
  output logic [1:0]       status_o,
  output logic             enable_o,
  output logic             cont_o,
  output logic             ld_start_o,
  output logic             adv_src_o,
  output logic             pause_evt_o,
  output logic             done_evt_o,
  output logic             src_done_evt_o
);
  run_state_e      state_q, state_n;
  logic            err_q, err_n;
  logic            en_q, en_n;
  logic            cont_q, cont_n;
  logic [EV_W-1:0] ev_n, ev_q;
  done_act_e       act;

  rc_done_decode #(
    .CMD_W(CMD_W), .STOP_CMD(STOP_CMD), .HALT_CMD(HALT_CMD)
  ) i_dec (
    .mem_desc(mem_desc),
    .cmd     (xfer_cmd),
    .act     (act)
  );

  always_comb begin
    state_n = state_q;
    err_n   = err_q;
    en_n    = en_q;
    cont_n  = cont_q;
    ev_n    = '0;
    if (state_q == ST_RUN) begin
      if (fetch_err) begin
        state_n = ST_OFF;
        err_n   = 1'b1;
      end else if (xfer_done) begin
        ev_n[EV_DONE] = 1'b1;
        ev_n[EV_SRC]  = xfer_intr;
        case (act)
          ACT_FINISH: begin
            state_n = ST_OFF;
            en_n    = 1'b0;
          end
          ACT_HOLD: begin
            state_n        = ST_HOLD;
            ev_n[EV_PAUSE] = 1'b1;
          end
          default: ev_n[EV_ADV] = 1'b1;
        endcase
      end
    end else if (ctl_wr) begin
      en_n   = ctl_en;
      cont_n = ctl_cont;
      if (ctl_en && state_q == ST_OFF) begin
        err_n       = 1'b0;
        ev_n[EV_LD] = 1'b1;
        state_n     = ST_RUN;
      end else if (ctl_en && ctl_cont && state_q == ST_HOLD) begin
        err_n        = 1'b0;
        ev_n[EV_LD]  = ctl_cont_start;
        ev_n[EV_ADV] = !ctl_cont_start;
        cont_n       = 1'b0;
        state_n      = ST_RUN;
      end else if (!ctl_en && ctl_cont && state_q == ST_HOLD) begin
        state_n = ST_OFF;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_OFF;
      err_q   <= 1'b0;
      en_q    <= 1'b0;
      cont_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      err_q   <= err_n;
      en_q    <= en_n;
      cont_q  <= cont_n;
    end
  end

  rc_pulse_reg #(.W(EV_W)) i_ev (
    .clk(clk), .rst(rst), .d(ev_n), .q(ev_q)
  );

  assign status_o       = err_q ? STATUS_FAULT : state_q;
  assign enable_o       = en_q;
  assign cont_o         = cont_q;
  assign ld_start_o     = ev_q[EV_LD];
  assign adv_src_o      = ev_q[EV_ADV];
  assign pause_evt_o    = ev_q[EV_PAUSE];
  assign done_evt_o     = ev_q[EV_DONE];
  assign src_done_evt_o = ev_q[EV_SRC];

  AST_START_RELOADS: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_OFF && ctl_wr && ctl_en) |=> (ld_start_o && status_o == 2'd1)); // R2
  AST_RESUME_ONE_REQ: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_HOLD && ctl_wr && ctl_en && ctl_cont) |=> (status_o == 2'd1 && (ld_start_o != adv_src_o) && !cont_o)); // R3
  AST_FAULT_STATUS: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RUN && fetch_err) |=> (status_o == STATUS_FAULT && !done_evt_o)); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RUN && xfer_done && !fetch_err) |=> done_evt_o); // R7
  AST_REG_MODE_STOPS: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RUN && xfer_done && !fetch_err && !mem_desc) |=> (!enable_o && status_o == 2'd0)); // R5
  AST_PAUSE_HELD: assert property (@(posedge clk) disable iff (rst)
    pause_evt_o |-> status_o == 2'd2); // R6
  AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ld_start_o, adv_src_o})); // R3
  AST_IDLE_NO_DONE: assert property (@(posedge clk) disable iff (rst)
    (state_q != ST_RUN) |=> !done_evt_o); // R10
endmodule

// File: tb/test_dma_run_ctrl.sv
`timescale 1ns/100ps
module test_dma_run_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ctl_wr = 0, ctl_en = 0, ctl_cont = 0, ctl_cont_start = 0;
  logic       mem_desc = 1;
  logic       xfer_done = 0, xfer_intr = 0, fetch_err = 0;
  logic [1:0] xfer_cmd = 0;
  logic [1:0] status_o;
  logic       enable_o, cont_o, ld_start_o, adv_src_o;
  logic       pause_evt_o, done_evt_o, src_done_evt_o;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  dma_run_ctrl i_dma_run_ctrl (
    .clk(clk), .rst(rst),
    .ctl_wr(ctl_wr), .ctl_en(ctl_en), .ctl_cont(ctl_cont), .ctl_cont_start(ctl_cont_start),
    .mem_desc(mem_desc),
    .xfer_done(xfer_done), .xfer_cmd(xfer_cmd), .xfer_intr(xfer_intr), .fetch_err(fetch_err),
    .status_o(status_o), .enable_o(enable_o), .cont_o(cont_o),
    .ld_start_o(ld_start_o), .adv_src_o(adv_src_o),
    .pause_evt_o(pause_evt_o), .done_evt_o(done_evt_o), .src_done_evt_o(src_done_evt_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // outputs compared as one vector: {status,enable,cont,ld,adv,pause,done,src}
  task automatic chk_all(input string tag, input logic [1:0] st, input logic en, input logic co,
                         input logic ld, input logic adv, input logic pa, input logic dn, input logic sd);
    chk(tag, {status_o, enable_o, cont_o, ld_start_o, adv_src_o, pause_evt_o, done_evt_o, src_done_evt_o},
             {st, en, co, ld, adv, pa, dn, sd});
  endtask

  task automatic wr(input logic en, input logic co, input logic cs);
    @(negedge clk);
    ctl_wr = 1; ctl_en = en; ctl_cont = co; ctl_cont_start = cs;
    @(negedge clk);
    ctl_wr = 0; ctl_en = 0; ctl_cont = 0; ctl_cont_start = 0;
  endtask

  task automatic eng(input logic dn, input logic [1:0] cmd, input logic intr, input logic fe);
    @(negedge clk);
    xfer_done = dn; xfer_cmd = cmd; xfer_intr = intr; fetch_err = fe;
    @(negedge clk);
    xfer_done = 0; xfer_cmd = 0; xfer_intr = 0; fetch_err = 0;
  endtask

  task automatic t_reset;
    chk_all("R1 reset state", 2'd0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_start_and_ignore;
    wr(1, 0, 0);
    chk_all("R2 start from off", 2'd1, 1, 0, 1, 0, 0, 0, 0);
    wr(1, 1, 1);
    chk_all("R9 write while running", 2'd1, 1, 0, 0, 0, 0, 0, 0);
    wr(0, 0, 0);
    chk_all("R9 disable write while running", 2'd1, 1, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_next_and_halt;
    eng(1, 2'd0, 0, 0);
    chk_all("R6 R7 cmd0 steps, no src event", 2'd1, 1, 0, 0, 1, 0, 1, 0);
    eng(1, 2'd3, 1, 0);
    chk_all("R6 R7 cmd3 steps with src event", 2'd1, 1, 0, 0, 1, 0, 1, 1);
    eng(1, 2'd1, 0, 0);
    chk_all("R6 halt enters held", 2'd2, 1, 0, 0, 0, 1, 1, 0);
    eng(1, 2'd0, 1, 0);
    chk_all("R10 done ignored while held", 2'd2, 1, 0, 0, 0, 0, 0, 0);
    eng(0, 2'd0, 0, 1);
    chk_all("R10 fetch error ignored while held", 2'd2, 1, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_resume;
    wr(1, 1, 0);
    chk_all("R3 resume steps source", 2'd1, 1, 0, 0, 1, 0, 0, 0);
    eng(1, 2'd1, 0, 0);
    wr(1, 1, 1);
    chk_all("R3 resume reloads from start", 2'd1, 1, 0, 1, 0, 0, 0, 0);
    eng(1, 2'd1, 0, 0);
    wr(1, 0, 0);
    chk_all("R3 enable without resume stays held", 2'd2, 1, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_leave_hold;
    wr(0, 1, 0);
    chk_all("R4 leave hold to off", 2'd0, 0, 1, 0, 0, 0, 0, 0);
    eng(1, 2'd0, 0, 0);
    chk_all("R10 done ignored while off", 2'd0, 0, 1, 0, 0, 0, 0, 0);
  endtask

  task automatic t_stop;
    wr(1, 0, 0);
    chk_all("R2 restart", 2'd1, 1, 0, 1, 0, 0, 0, 0);
    eng(1, 2'd2, 1, 0);
    chk_all("R5 stop command", 2'd0, 0, 0, 0, 0, 0, 1, 1);
    mem_desc = 0;
    wr(1, 0, 0);
    eng(1, 2'd0, 0, 0);
    chk_all("R5 register mode finishes", 2'd0, 0, 0, 0, 0, 0, 1, 0);
    wr(1, 0, 0);
    eng(1, 2'd1, 0, 0);
    chk_all("R5 register mode ignores halt", 2'd0, 0, 0, 0, 0, 0, 1, 0);
    mem_desc = 1;
  endtask

  task automatic t_fault;
    wr(1, 0, 0);
    eng(0, 2'd0, 0, 1);
    chk_all("R8 fetch error faults", 2'd3, 1, 0, 0, 0, 0, 0, 0);
    @(negedge clk);
    chk("R1 fault status sticky", status_o, 3);
    wr(1, 0, 0);
    chk_all("R2 start clears fault", 2'd1, 1, 0, 1, 0, 0, 0, 0);
    eng(1, 2'd0, 1, 1);
    chk_all("R11 error beats done", 2'd3, 1, 0, 0, 0, 0, 0, 0);
    wr(1, 0, 0);
    eng(1, 2'd1, 0, 0);
    chk("R1 held status", status_o, 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_start_and_ignore();
    t_next_and_halt();
    t_resume();
    t_leave_hold();
    t_stop();
    t_fault();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule